// File: doc/BRIEF.md
# Time-Slot Interchange Output Switch

This block builds the outgoing side of a time-slot interchange. Eight serial output streams each carry 32 byte-wide channels per frame, so one frame holds 256 bit cells of one clock cycle each. Every output channel has its own connection entry: an 8-bit low byte and three control bits. In switched mode, the low byte is an address into a 256 x 8 input data memory, and the byte stored there is sent. In message mode, the low byte itself is sent, and it repeats every frame until software rewrites it. The connection store and the data store are held inside the block. Each has a plain synchronous write port, fed by the input deserializer and the processor bus logic, which sit outside this block.

Each byte is fetched one channel slot ahead of the slot that sends it. The fetch reads one stream per bit cell, so a single read port on each store is enough. Each output stream has a data line and a drive-enable line, so an enclosing pad ring can build tri-state outputs. A global drive-enable input gates all eight enables. A global broadcast input forces every channel into enabled message mode. A control serial output sends one control bit per connection location across the frame.

The parameters are powers of two, and `NUM_STREAMS` is no larger than `BYTE_W`.

Top module: `tsi_out_switch`

## Requirements
- R1: Bit cell n of a frame (0..255) belongs to channel n/8, bit position n%8. If `frame_sync_i` is high in a cycle, the next cycle is cell 0. Otherwise the cell number advances by one each cycle and wraps from 255 to 0.
- R2: A connection location's index is stream*32 + channel. When control bit 2 (message) is 0, the channel sends the data-store byte at the address held in its low byte. A data-store address is input stream*32 + input channel.
- R3: When control bit 2 is 1, the channel sends its low byte. The same byte is sent in every frame while the entry is unchanged.
- R4: Within a channel slot, bit cell b carries bit 7-b of the byte, so the most significant bit goes first.
- R5: Control bit 0 is the channel's drive enable. When it is 0, that stream's `ser_oe_o` bit is low for the whole slot.
- R6: While `ode_i` is low, all `ser_oe_o` bits are low in the same cycle.
- R7: While `msg_all_i` is high, every channel behaves as if control bits 2 and 0 were both 1. It applies to fetches made while it is high, so it reaches the outputs from the next channel slot on.
- R8: In cell n = 8c + b, `ctl_o` carries control bit 1 of location b*32 + c.
- R9: The entry and source byte for stream s, channel c are read during cell 8(c-1)+s (mod 256). A write made in or after that cell is first seen in the following frame.
- R10: Reset clears every connection entry to zero, drives all `ser_oe_o` bits and `ctl_o` low, and starts at cell 0. The first channel slot after reset is not driven.
- R11: A `frame_sync_i` pulse in any cell other than 255 leaves the following channel-0 slot undriven on every stream, with `ctl_o` low. Channel 1 onward is normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-cell clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_sync_i | input | 1 | High in the cell before cell 0 |
| ode_i | input | 1 | Global output drive enable |
| msg_all_i | input | 1 | Broadcast: all channels in enabled message mode |
| cm_we_i | input | 1 | Connection entry write strobe |
| cm_waddr_i | input | 8 | Connection location, stream*32+channel |
| cm_wlow_i | input | 8 | Low byte: source address or message byte |
| cm_whigh_i | input | 3 | Control bits: 2 message, 1 control-stream bit, 0 drive enable |
| dm_we_i | input | 1 | Data store write strobe |
| dm_waddr_i | input | 8 | Data store address, stream*32+channel |
| dm_wdata_i | input | 8 | Data store write byte |
| ser_o | output | 8 | Serial data, one bit per output stream |
| ser_oe_o | output | 8 | Drive enable, one bit per output stream |
| ctl_o | output | 1 | Control serial output |

## Verification
The assertions assume that `frame_sync_i` is either a single-cycle pulse or held low. They also assume that `ode_i` and `msg_all_i` only change away from the clock edge. The bench drives every input at the falling edge and raises `frame_sync_i` for exactly one cell. It fires the pulse once at cell 255 and once misaligned, at cell 100. Between the two pulses the counter runs freely, so the bench's own cell count stays in step with the design. It writes the stores only outside the window that a frame check depends on, except in the one scenario that aims a write at the exact fetch cell.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  // control bits of a connection entry
  typedef struct packed {
    logic msg;  // bit 2: message mode
    logic ctl;  // bit 1: control serial stream bit
    logic en;   // bit 0: channel drive enable
  } conn_hi_t;
  localparam int HI_W = 3;
endpackage

// File: rtl/tsi_cell_timer.sv
module tsi_cell_timer #(
  parameter int CELL_W = 8,
  parameter int BIT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_sync_i,
  output logic [CELL_W-1:0] cnt_o,
  output logic              slot_last_o,
  output logic              frame_last_o
);
  logic [CELL_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (frame_sync_i) cnt_q <= '0;
    else                   cnt_q <= cnt_q + CELL_W'(1);
  end

  assign cnt_o        = cnt_q;
  assign slot_last_o  = &cnt_q[BIT_W-1:0];
  assign frame_last_o = &cnt_q;

  assert_cell_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_sync_i |=> cnt_q == $past(cnt_q) + CELL_W'(1));
  assert_sync_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_sync_i |=> cnt_q == '0);
endmodule

// File: rtl/tsi_ram.sv
module tsi_ram #(
  parameter int DEPTH          = 256,
  parameter int WIDTH          = 8,
  parameter bit CLEAR_ON_RESET = 1'b0,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem [DEPTH];

  generate
    if (CLEAR_ON_RESET) begin : g_clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we_i) begin
          mem[waddr_i] <= wdata_i;
        end
      end
    end else begin : g_plain
      // writes are dropped while reset is held
      always_ff @(posedge clk_i) begin
        if (we_i && rst_ni) mem[waddr_i] <= wdata_i;
      end
    end
  endgenerate

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/tsi_slot_fetch.sv
module tsi_slot_fetch
  import tsi_pkg::*;
#(
  parameter int NUM_STREAMS = 8,
  parameter int BYTE_W      = 8,
  localparam int ST_W  = $clog2(NUM_STREAMS),
  localparam int BIT_W = $clog2(BYTE_W)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   frame_sync_i,
  input  logic                   frame_last_i,
  input  logic                   slot_last_i,
  input  logic [BIT_W-1:0]       cell_bit_i,
  input  logic                   ode_i,
  input  logic                   msg_all_i,
  input  conn_hi_t               cm_hi_i,
  input  logic [BYTE_W-1:0]      cm_lo_i,
  input  logic [BYTE_W-1:0]      dm_data_i,
  output logic [NUM_STREAMS-1:0] ser_o,
  output logic [NUM_STREAMS-1:0] ser_oe_o,
  output logic                   ctl_o
);
  localparam logic [BIT_W:0]     NS_L    = (BIT_W+1)'(NUM_STREAMS);
  localparam logic [BIT_W-1:0]   MSB_SEL = BIT_W'(BYTE_W-1);

  logic [NUM_STREAMS-1:0][BYTE_W-1:0] nxt_byte, cur_byte;
  logic [NUM_STREAMS-1:0]             nxt_oe, cur_oe, nxt_ctl, cur_ctl;
  logic [ST_W-1:0]                    fetch_idx;
  logic                               fetch_ok, f_oe;
  logic [BYTE_W-1:0]                  f_byte;
  logic [BIT_W-1:0]                   bit_sel;

  // stream s is fetched in bit cell s of the preceding slot
  assign fetch_ok  = {1'b0, cell_bit_i} < NS_L;
  assign fetch_idx = cell_bit_i[ST_W-1:0];
  assign f_oe      = cm_hi_i.en | msg_all_i;
  assign f_byte    = (cm_hi_i.msg | msg_all_i) ? cm_lo_i : dm_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nxt_byte <= '0;
      nxt_oe   <= '0;
      nxt_ctl  <= '0;
      cur_byte <= '0;
      cur_oe   <= '0;
      cur_ctl  <= '0;
    end else begin
      if (fetch_ok) begin
        nxt_byte[fetch_idx] <= f_byte;
        nxt_oe[fetch_idx]   <= f_oe;
        nxt_ctl[fetch_idx]  <= cm_hi_i.ctl;
      end
      if (frame_sync_i && !frame_last_i) begin
        // misaligned frame start: prefetched slot is for the wrong channel
        cur_oe  <= '0;
        cur_ctl <= '0;
      end else if (slot_last_i) begin
        for (int s = 0; s < NUM_STREAMS; s++) begin
          if (fetch_ok && fetch_idx == ST_W'(s)) begin
            cur_byte[s] <= f_byte;
            cur_oe[s]   <= f_oe;
            cur_ctl[s]  <= cm_hi_i.ctl;
          end else begin
            cur_byte[s] <= nxt_byte[s];
            cur_oe[s]   <= nxt_oe[s];
            cur_ctl[s]  <= nxt_ctl[s];
          end
        end
      end
    end
  end

  assign bit_sel = MSB_SEL - cell_bit_i;

  always_comb begin
    for (int s = 0; s < NUM_STREAMS; s++) ser_o[s] = cur_byte[s][bit_sel];
  end

  assign ser_oe_o = ode_i ? cur_oe : '0;
  assign ctl_o    = fetch_ok & cur_ctl[fetch_idx];

  assert_hold_in_slot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slot_last_i && !frame_sync_i) |=>
      ($stable(cur_byte) && $stable(cur_oe) && $stable(cur_ctl)));
  assert_resync_blank_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_sync_i && !frame_last_i) |=> (ser_oe_o == '0 && !ctl_o));
  assert_ode_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ode_i |-> ser_oe_o == '0);
  assert_bcast_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_all_i && fetch_ok) |=> nxt_oe[$past(fetch_idx)]);
endmodule

// File: rtl/tsi_out_switch.sv
module tsi_out_switch
  import tsi_pkg::*;
#(
  parameter int NUM_STREAMS = 8,
  parameter int NUM_CHANS   = 32,
  parameter int BYTE_W      = 8
) (
  input  logic                                          clk_i,
  input  logic                                          rst_ni,
  input  logic                                          frame_sync_i,
  input  logic                                          ode_i,
  input  logic                                          msg_all_i,
  input  logic                                          cm_we_i,
  input  logic [$clog2(NUM_STREAMS)+$clog2(NUM_CHANS)-1:0] cm_waddr_i,
  input  logic [BYTE_W-1:0]                             cm_wlow_i,
  input  logic [2:0]                                    cm_whigh_i,
  input  logic                                          dm_we_i,
  input  logic [$clog2(NUM_STREAMS)+$clog2(NUM_CHANS)-1:0] dm_waddr_i,
  input  logic [BYTE_W-1:0]                             dm_wdata_i,
  output logic [NUM_STREAMS-1:0]                        ser_o,
  output logic [NUM_STREAMS-1:0]                        ser_oe_o,
  output logic                                          ctl_o
);
  localparam int ST_W   = $clog2(NUM_STREAMS);
  localparam int CH_W   = $clog2(NUM_CHANS);
  localparam int BIT_W  = $clog2(BYTE_W);
  localparam int AW     = ST_W + CH_W;
  localparam int LOCS   = NUM_STREAMS * NUM_CHANS;
  localparam int CELL_W = CH_W + BIT_W;
  localparam int CM_W   = HI_W + BYTE_W;

  logic [CELL_W-1:0] cnt;
  logic              slot_last, frame_last;
  logic [BIT_W-1:0]  cell_bit;
  logic [CH_W-1:0]   chan, next_chan;
  logic [AW-1:0]     cm_raddr;
  logic [CM_W-1:0]   cm_rdata;
  logic [BYTE_W-1:0] cm_lo, dm_rdata;
  conn_hi_t          cm_hi;

  tsi_cell_timer #(.CELL_W(CELL_W), .BIT_W(BIT_W)) u_timer (
    .clk_i, .rst_ni, .frame_sync_i,
    .cnt_o(cnt), .slot_last_o(slot_last), .frame_last_o(frame_last)
  );

  assign cell_bit  = cnt[BIT_W-1:0];
  assign chan      = cnt[CELL_W-1:BIT_W];
  assign next_chan = chan + CH_W'(1);
  assign cm_raddr  = {cell_bit[ST_W-1:0], next_chan};

  tsi_ram #(.DEPTH(LOCS), .WIDTH(CM_W), .CLEAR_ON_RESET(1'b1)) u_conn (
    .clk_i, .rst_ni, .we_i(cm_we_i), .waddr_i(cm_waddr_i),
    .wdata_i({cm_whigh_i, cm_wlow_i}), .raddr_i(cm_raddr), .rdata_o(cm_rdata)
  );

  assign cm_lo = cm_rdata[BYTE_W-1:0];
  assign cm_hi = conn_hi_t'(cm_rdata[CM_W-1:BYTE_W]);

  tsi_ram #(.DEPTH(LOCS), .WIDTH(BYTE_W), .CLEAR_ON_RESET(1'b0)) u_data (
    .clk_i, .rst_ni, .we_i(dm_we_i), .waddr_i(dm_waddr_i),
    .wdata_i(dm_wdata_i), .raddr_i(cm_lo[AW-1:0]), .rdata_o(dm_rdata)
  );

  tsi_slot_fetch #(.NUM_STREAMS(NUM_STREAMS), .BYTE_W(BYTE_W)) u_fetch (
    .clk_i, .rst_ni, .frame_sync_i,
    .frame_last_i(frame_last), .slot_last_i(slot_last), .cell_bit_i(cell_bit),
    .ode_i, .msg_all_i, .cm_hi_i(cm_hi), .cm_lo_i(cm_lo), .dm_data_i(dm_rdata),
    .ser_o, .ser_oe_o, .ctl_o
  );
endmodule

// File: tb/tsi_out_switch_tb.sv
module tsi_out_switch_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic       frame_sync_i = 1'b0, ode_i = 1'b1, msg_all_i = 1'b0;
  logic       cm_we_i = 1'b0, dm_we_i = 1'b0;
  logic [7:0] cm_waddr_i = '0, cm_wlow_i = '0, dm_waddr_i = '0, dm_wdata_i = '0;
  logic [2:0] cm_whigh_i = '0;
  logic [7:0] ser_o, ser_oe_o;
  logic       ctl_o;

  logic [7:0] sh_lo [256];
  logic [2:0] sh_hi [256];
  logic [7:0] sh_dm [256];
  int errs = 0, checks = 0, bcell = 0;

  always #2 clk_i = ~clk_i;

  tsi_out_switch dut_i (.*);

  task automatic step();
    @(posedge clk_i);
    if (frame_sync_i) bcell = 0; else bcell = (bcell + 1) % 256;
    @(negedge clk_i);
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s cell=%0d actual=%0h expected=%0h", req, what, bcell, act, exp);
    end
  endtask

  task automatic wr_cm(int a, logic [7:0] lo, logic [2:0] hi);
    cm_we_i = 1; cm_waddr_i = 8'(a); cm_wlow_i = lo; cm_whigh_i = hi;
    step();
    cm_we_i = 0;
    sh_lo[a] = lo; sh_hi[a] = hi;
  endtask

  task automatic wr_dm(int a, logic [7:0] d);
    dm_we_i = 1; dm_waddr_i = 8'(a); dm_wdata_i = d;
    step();
    dm_we_i = 0;
    sh_dm[a] = d;
  endtask

  task automatic to_frame_start();
    repeat (256) step();
    while (bcell != 0) step();
  endtask

  task automatic check_cell(string req);
    int c = bcell / 8, b = bcell % 8;
    for (int s = 0; s < 8; s++) begin
      int i = s * 32 + c;
      logic en = sh_hi[i][0] | msg_all_i;
      logic m  = sh_hi[i][2] | msg_all_i;
      logic [7:0] byt = m ? sh_lo[i] : sh_dm[sh_lo[i]];
      logic eoe = ode_i & en;
      chk(ser_oe_o[s] == eoe, req, $sformatf("oe s%0d", s), ser_oe_o[s], eoe);
      if (eoe) chk(ser_o[s] == byt[7-b], req, $sformatf("data s%0d", s), ser_o[s], byt[7-b]);
    end
    chk(ctl_o == sh_hi[b*32+c][1], req, "ctl", ctl_o, sh_hi[b*32+c][1]);
  endtask

  task automatic check_frame(string req);
    for (int n = 0; n < 256; n++) begin
      check_cell(req);
      step();
    end
  endtask

  // R10: reset state and first slot undriven
  task automatic t_reset();
    #1 rst_ni = 0;
    repeat (3) @(negedge clk_i);
    chk(ser_oe_o == 8'h00, "R10", "oe in reset", ser_oe_o, 0);
    chk(ctl_o == 1'b0, "R10", "ctl in reset", ctl_o, 0);
    rst_ni = 1; bcell = 0;
    for (int n = 0; n < 8; n++) begin
      chk(ser_oe_o == 8'h00, "R10", "first slot oe", ser_oe_o, 0);
      step();
    end
    for (int i = 0; i < 256; i++) begin sh_lo[i] = 0; sh_hi[i] = 0; sh_dm[i] = 0; end
  endtask

  // R2 R4: switched mode through the data store
  task automatic t_switched();
    for (int i = 0; i < 256; i++) wr_dm(i, 8'((i * 53 + 7) % 256));
    for (int i = 0; i < 256; i++) wr_cm(i, 8'((i * 37 + 11) % 256), 3'b001);
    to_frame_start();
    check_frame("R2_R4");
  endtask

  // R3: message bytes, repeated over two frames
  task automatic t_message();
    for (int i = 0; i < 256; i++) wr_cm(i, 8'((i * 29 + 3) % 256), 3'b101);
    to_frame_start();
    check_frame("R3");
    check_frame("R3");
  endtask

  // R5 R8: every control combination, including undriven channels
  task automatic t_mixed();
    for (int i = 0; i < 256; i++) wr_cm(i, 8'((i * 71 + 19) % 256), 3'((i * 5 + i / 8) % 8));
    to_frame_start();
    check_frame("R5_R8");
  endtask

  // R6: global drive enable low
  task automatic t_ode();
    ode_i = 0;
    check_frame("R6");
    ode_i = 1;
  endtask

  // R7: broadcast forces enabled message mode
  task automatic t_bcast();
    msg_all_i = 1;
    to_frame_start();
    check_frame("R7");
    msg_all_i = 0;
    to_frame_start();
    check_frame("R7");
  endtask

  // R1 R11: aligned and misaligned frame pulses
  task automatic t_sync();
    while (bcell != 255) step();
    frame_sync_i = 1; step(); frame_sync_i = 0;
    chk(bcell == 0, "R1", "bench cell", bcell, 0);
    check_frame("R1");
    while (bcell != 100) step();
    frame_sync_i = 1; step(); frame_sync_i = 0;
    for (int n = 0; n < 8; n++) begin
      chk(ser_oe_o == 8'h00, "R11", "resync oe", ser_oe_o, 0);
      chk(ctl_o == 1'b0, "R11", "resync ctl", ctl_o, 0);
      step();
    end
    for (int n = 0; n < 8; n++) begin
      check_cell("R11_R1");
      step();
    end
  endtask

  // R9: a write in the fetch cell is seen only in the next frame
  task automatic t_pipeline();
    int loc = 3 * 32 + 5;
    wr_cm(loc, 8'hA5, 3'b101);
    to_frame_start();
    while (bcell != 35) step();
    cm_we_i = 1; cm_waddr_i = 8'(loc); cm_wlow_i = 8'h3C; cm_whigh_i = 3'b101;
    step();
    cm_we_i = 0;
    while (bcell != 40) step();
    for (int b = 0; b < 8; b++) begin
      logic [7:0] old_b = 8'hA5;
      chk(ser_o[3] == old_b[7-b], "R9", "same-frame data", ser_o[3], old_b[7-b]);
      step();
    end
    while (bcell != 40) step();
    for (int b = 0; b < 8; b++) begin
      logic [7:0] new_b = 8'h3C;
      chk(ser_o[3] == new_b[7-b], "R9", "next-frame data", ser_o[3], new_b[7-b]);
      step();
    end
    sh_lo[loc] = 8'h3C;
  endtask

  initial begin
    #(4 * 150000);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_switched();
    t_message();
    t_mixed();
    t_ode();
    t_bcast();
    t_sync();
    t_pipeline();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule